// File: doc/BRIEF.md
# Fractional-Rate Asynchronous Serial Port

This block is a full-duplex asynchronous serial port with one transmit line and one receive line. Each character is framed as 8N1: a low start bit, eight data bits sent least-significant bit first, and a high stop bit. Between frames the line rests high. The transmit side takes one byte at a time through a valid/ready handshake. The receive side reports each completed byte with a one-cycle valid pulse and a framing-error flag. Both directions run independently and at the same time.

The bit rate is set by a 16-bit rate word. The word accumulates into a phase register on every master clock, and the register wraps at 2^19. This gives baud = word × f_clk / 2^19. The low 15 bits of the same register produce the 16× oversampling ticks, which can arrive at up to two per clock. Both engines count these ticks in 1/16-bit steps, so the full 16-bit word range can be used.

A rate-word write port lets the rate change at any time. The accumulator keeps running and only its increment changes, so a frame already on the line is not broken. After reset the word is 77, which is about 600 baud on a 4.096 MHz clock.

Top module: `uart_frac`

## Requirements
- R1: While rst_n is low at a clock edge, the port resets. Afterwards txd is 1, tx_ready is 1, rx_valid is 0, and the rate word is 77, so one bit lasts 2^19/77 ≈ 6809 clocks.
- R2: A transmitted frame is txd = 0 for one bit time, then data bits 0 to 7 (bit 0 first), one bit time each, then txd = 1 for one bit time. Between frames txd stays 1.
- R3: One bit time is 2^19 / word master clocks. At word 8192, the time from accepting a byte until tx_ready returns is 10 × 64 = 640 clocks.
- R4: A byte is accepted at a clock edge where tx_valid and tx_ready are both 1. tx_ready is 0 from the next cycle until the stop bit has ended. A byte offered as soon as tx_ready returns is sent straight after the previous frame.
- R5: A correctly framed byte on rxd appears on rx_data with a single-cycle rx_valid pulse and rx_frame_err = 0. The first bit received is placed in rx_data[0].
- R6: If the stop bit is sampled as 0, the byte is still reported, with rx_frame_err = 1. No further byte is reported until rxd has returned to 1 and a new start bit begins.
- R7: A low pulse on rxd that ends before the middle of the start bit is ignored and produces no rx_valid.
- R8: A rate word written with rate_we = 1 is used from the next clock on. A write during a frame changes the length of the remaining bits but keeps the frame's bit count and content.
- R9: The transmitter and receiver work at the same time without affecting each other.
- R10: Word 65535 (≈ 8 clocks per bit, two oversample ticks per clock) transmits and receives correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_we | input | 1 | Load rate_wdata into the rate word |
| rate_wdata | input | 16 | New rate word (baud × 2^19 / f_clk) |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter idle, a byte can be accepted |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse: rx_data and rx_frame_err are new |
| rx_frame_err | output | 1 | Stop bit of the reported byte was low |

## Verification
The assertions check the following on every cycle:
- a rate write lands in the rate word one clock later;
- reset reloads the default word;
- txd stays high while the transmitter is idle;
- an accepted byte drops tx_ready and starts the start bit on the next edge;
- rx_valid never lasts two cycles;
- a framing error always leaves the receiver waiting for a high line.

Some behaviour can only be shown by the bench's scenarios:
- frame bit order and bit timing at the default, medium and maximum rates;
- rejection of a short start glitch;
- a rate change in the middle of a frame with the transmitter looped back to the receiver;
- simultaneous transmit and receive.

// File: rtl/ufr_pkg.sv
// Package ufr_pkg
// Shared constants and types for the fractional-rate serial port.
// Assumes: the 2^19 rate accumulator is split into a 15-bit shared fraction
// (oversample carries) and a 4-bit per-engine phase (sixteenths of a bit).
package ufr_pkg;

    localparam int RATE_W_DEF    = 16;
    localparam int DATA_W_DEF    = 8;
    localparam int PH_W          = 4;   // log2 of the oversampling factor
    localparam int DEF_RATE_WORD = 77;  // about 600 baud at 4.096 MHz

    typedef logic [1:0] tick_cnt_t;     // oversample carries per clock (0..2)

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_t;

endpackage

// File: rtl/ufr_rate_gen.sv
// Module ufr_rate_gen
// Holds the rate word and the shared fractional accumulator. Every clock the
// word is added to the fraction, and the carries out of the fraction are
// reported as the number of 16x oversample ticks for this clock.
// Assumes: the fraction is RATE_W-1 bits wide, so at most two carries occur
// per clock.
module ufr_rate_gen #(
    parameter int                RATE_W   = ufr_pkg::RATE_W_DEF,
    parameter logic [RATE_W-1:0] DEF_RATE = RATE_W'(ufr_pkg::DEF_RATE_WORD)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rate_we,
    input  logic [RATE_W-1:0]    rate_wdata,
    output ufr_pkg::tick_cnt_t   tick_n
);
    localparam int FRAC_W = RATE_W - 1;
    localparam int SUM_W  = RATE_W + 1;

    logic [RATE_W-1:0] rate_q;
    logic [FRAC_W-1:0] frac_q;
    logic [SUM_W-1:0]  sum;

    assign sum    = {2'b00, frac_q} + {1'b0, rate_q};
    assign tick_n = sum[SUM_W-1:FRAC_W];

    // Rate word register: default on reset, loaded by the write port.
    always_ff @(posedge clk) begin
        if (!rst_n)       rate_q <= DEF_RATE;
        else if (rate_we) rate_q <= rate_wdata;
    end

    // Free-running fraction: only its increment changes on a rate write.
    always_ff @(posedge clk) begin
        if (!rst_n) frac_q <= '0;
        else        frac_q <= sum[FRAC_W-1:0];
    end

    // R8: a written word is in use from the next clock
    a_r8_rate_load: assert property (@(posedge clk) disable iff (!rst_n)
        rate_we |=> rate_q == $past(rate_wdata));

    // R1: leaving reset always starts from the default word
    a_r1_default_rate: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> rate_q == DEF_RATE);

endmodule

// File: rtl/ufr_bit_phase.sv
// Module ufr_bit_phase
// Counts oversample ticks in sixteenths of a bit for one engine. The count
// restarts at zero when a frame begins. The parameter picks which event is
// flagged: the end of a bit (transmitter) or the bit centre (receiver).
// Assumes: tick_n is at most 2, so no event can be skipped.
module ufr_bit_phase #(
    parameter int PH_W   = ufr_pkg::PH_W,
    parameter bit AT_MID = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  ufr_pkg::tick_cnt_t tick_n,
    output logic               mark
);
    logic [PH_W-1:0] ph_q;
    logic [PH_W:0]   nxt;

    assign nxt = {1'b0, ph_q} + {{(PH_W-1){1'b0}}, tick_n};

    generate
        if (AT_MID) begin : g_mid
            assign mark = run && !ph_q[PH_W-1] && (nxt[PH_W-1] || nxt[PH_W]);
        end else begin : g_end
            assign mark = run && nxt[PH_W];
        end
    endgenerate

    // Phase within the current bit, restarted at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) ph_q <= '0;
        else if (run)          ph_q <= nxt[PH_W-1:0];
    end

endmodule

// File: rtl/ufr_tx.sv
// Module ufr_tx
// 8N1 transmitter. Accepts one byte through valid/ready, then drives the start
// bit, the data bits (LSB first) and the stop bit, each lasting 16 ticks.
// Assumes: tick_n comes from ufr_rate_gen.
module ufr_tx #(
    parameter int DATA_W = ufr_pkg::DATA_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ufr_pkg::tick_cnt_t tick_n,
    input  logic [DATA_W-1:0]  tx_data,
    input  logic               tx_valid,
    output logic               tx_ready,
    output logic               txd
);
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    logic              busy_q;
    logic              txd_q;
    logic [DATA_W:0]   sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              accept;
    logic              bit_end;

    assign tx_ready = !busy_q;
    assign txd      = txd_q;
    assign accept   = tx_valid && !busy_q;

    ufr_bit_phase #(.PH_W(ufr_pkg::PH_W), .AT_MID(1'b0)) i_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy_q),
        .restart (accept),
        .tick_n  (tick_n),
        .mark    (bit_end)
    );

    // Frame sequencer: load on accept, advance one bit at each bit end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            txd_q  <= 1'b1;
            sh_q   <= '1;
            cnt_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            txd_q  <= 1'b0;
            sh_q   <= {1'b1, tx_data};
            cnt_q  <= '0;
        end else if (busy_q && bit_end) begin
            if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
                busy_q <= 1'b0;
                txd_q  <= 1'b1;
            end else begin
                txd_q  <= sh_q[0];
                sh_q   <= {1'b1, sh_q[DATA_W:1]};
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    // R2: the line rests high while no frame is in progress
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && $past(tx_ready)) |-> txd);

    // R4: an accepted byte drops ready and begins the start bit
    a_r4_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_ready && !txd));

endmodule

// File: rtl/ufr_rx.sv
// Module ufr_rx
// Oversampling 8N1 receiver. It synchronises rxd and detects a falling edge,
// then confirms the start bit at its centre. It samples each data bit and the
// stop bit at their centres. After a low stop bit it waits for the line to go
// high again.
// Assumes: rxd is asynchronous; tick_n comes from ufr_rate_gen.
module ufr_rx #(
    parameter int DATA_W = ufr_pkg::DATA_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ufr_pkg::tick_cnt_t tick_n,
    input  logic               rxd,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_valid,
    output logic               rx_frame_err
);
    import ufr_pkg::*;

    localparam int CNT_W = $clog2(DATA_W);

    logic              s1_q, s2_q;
    rx_state_t         state_q;
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] data_q;
    logic              valid_q, err_q;
    logic              run, restart, mid;

    assign run     = (state_q == RX_START) || (state_q == RX_DATA) || (state_q == RX_STOP);
    assign restart = (state_q == RX_IDLE) && !s2_q;

    assign rx_data      = data_q;
    assign rx_valid     = valid_q;
    assign rx_frame_err = err_q;

    ufr_bit_phase #(.PH_W(PH_W), .AT_MID(1'b1)) i_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .tick_n  (tick_n),
        .mark    (mid)
    );

    // Two-flop synchroniser for the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= rxd;
            s2_q <= s1_q;
        end
    end

    // Receive state machine: start check, data shift, stop check, recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (!s2_q) state_q <= RX_START;
                end
                RX_START: begin
                    if (mid) begin
                        cnt_q   <= '0;
                        state_q <= s2_q ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (mid) begin
                        sh_q  <= {s2_q, sh_q[DATA_W-1:1]};
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(DATA_W - 1)) state_q <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (mid) begin
                        data_q  <= sh_q;
                        valid_q <= 1'b1;
                        err_q   <= !s2_q;
                        state_q <= s2_q ? RX_IDLE : RX_WAIT_HIGH;
                    end
                end
                RX_WAIT_HIGH: begin
                    if (s2_q) state_q <= RX_IDLE;
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    // R5: each byte is reported by a single-cycle pulse
    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6: a framing error always parks the receiver until the line is high
    a_r6_err_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_frame_err) |-> (state_q == RX_WAIT_HIGH));

    // R7: a start bit that is high at its centre returns to idle
    a_r7_glitch_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START && mid && s2_q) |=> (state_q == RX_IDLE && !rx_valid));

endmodule

// File: rtl/uart_frac.sv
// Module uart_frac
// Top of the fractional-rate serial port. It connects the shared rate
// generator to the independent transmitter and receiver (full duplex).
// Assumes: one master clock; rst_n is synchronous and active low.
module uart_frac #(
    parameter int                RATE_W   = ufr_pkg::RATE_W_DEF,
    parameter int                DATA_W   = ufr_pkg::DATA_W_DEF,
    parameter logic [RATE_W-1:0] DEF_RATE = RATE_W'(ufr_pkg::DEF_RATE_WORD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_frame_err
);
    ufr_pkg::tick_cnt_t tick_n;

    ufr_rate_gen #(.RATE_W(RATE_W), .DEF_RATE(DEF_RATE)) i_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_we    (rate_we),
        .rate_wdata (rate_wdata),
        .tick_n     (tick_n)
    );

    ufr_tx #(.DATA_W(DATA_W)) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_n   (tick_n),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .txd      (txd)
    );

    ufr_rx #(.DATA_W(DATA_W)) i_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_n       (tick_n),
        .rxd          (rxd),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err)
    );

endmodule

// File: tb/test_uart_frac.sv
// Scoreboard bench for uart_frac. Driver tasks push expected bytes into
// queues; a line monitor on txd and a monitor on rx_valid pop and compare.
module test_uart_frac;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_we = 1'b0;
    logic [15:0] rate_wdata = '0;
    logic [7:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        txd;
    logic        rxd;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_frame_err;

    logic        drv_rx = 1'b1;
    logic        loop_en = 1'b0;

    always #5 clk = ~clk;

    assign rxd = loop_en ? txd : drv_rx;

    uart_frac i_uart_frac (
        .clk          (clk),
        .rst_n        (rst_n),
        .rate_we      (rate_we),
        .rate_wdata   (rate_wdata),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .txd          (txd),
        .rxd          (rxd),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err)
    );

    int         checks = 0;
    int         fails = 0;
    int         bit_clks = 128;
    bit         tx_mon_en = 1'b0;
    int         rx_valid_cnt = 0;
    logic [7:0] tx_q[$];
    logic [8:0] rx_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_rate(input logic [15:0] w);
        @(negedge clk);
        rate_we    = 1'b1;
        rate_wdata = w;
        @(negedge clk);
        rate_we    = 1'b0;
    endtask

    // Transmit driver: offer one byte, optionally expect it on txd.
    task automatic send_tx(input logic [7:0] b, input bit expect_line);
        if (expect_line) tx_q.push_back(b);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = b;
        @(negedge clk);
        tx_valid = 1'b0;
        check(!tx_ready, "R4", "tx_ready after accept", int'(tx_ready), 0);
    endtask

    // Receive driver: serialise one frame onto rxd with a chosen stop level.
    task automatic send_rx(input logic [7:0] b, input logic stop_lvl);
        rx_q.push_back({~stop_lvl, b});
        drv_rx = 1'b0;
        wait_clks(bit_clks);
        for (int i = 0; i < 8; i++) begin
            drv_rx = b[i];
            wait_clks(bit_clks);
        end
        drv_rx = stop_lvl;
        wait_clks(bit_clks);
    endtask

    // Line monitor: decode frames on txd at bit centres (R2).
    initial begin
        logic       prev_txd;
        logic [7:0] got;
        logic [7:0] exp_b;
        prev_txd = 1'b1;
        forever begin
            @(negedge clk);
            if (tx_mon_en && prev_txd === 1'b1 && txd === 1'b0) begin
                wait_clks(bit_clks / 2);
                check(txd == 1'b0, "R2", "start bit level", int'(txd), 0);
                for (int i = 0; i < 8; i++) begin
                    wait_clks(bit_clks);
                    got[i] = txd;
                end
                wait_clks(bit_clks);
                check(txd == 1'b1, "R2", "stop bit level", int'(txd), 1);
                if (tx_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected frame on txd", int'(got), -1);
                end else begin
                    exp_b = tx_q.pop_front();
                    check(got == exp_b, "R2", "txd byte", int'(got), int'(exp_b));
                end
            end
            prev_txd = txd;
        end
    end

    // Receive monitor: compare every reported byte with the queue (R5, R6).
    initial begin
        logic [8:0] e;
        forever begin
            @(negedge clk);
            if (rst_n && rx_valid) begin
                rx_valid_cnt++;
                if (rx_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected rx byte", int'(rx_data), -1);
                end else begin
                    e = rx_q.pop_front();
                    check(rx_data == e[7:0], "R5", "rx_data", int'(rx_data), int'(e[7:0]));
                    check(rx_frame_err == e[8], "R6", "rx_frame_err",
                          int'(rx_frame_err), int'(e[8]));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        int c0;

        // R1: reset state
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(2);
        check(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
        check(tx_ready == 1'b1, "R1", "tx_ready after reset", int'(tx_ready), 1);
        check(rx_valid == 1'b0, "R1", "rx_valid after reset", int'(rx_valid), 0);

        // R1: default word 77 gives a start bit of about 6809 clocks
        tx_mon_en = 1'b0;
        send_tx(8'hFF, 1'b0);
        n = 1;
        while (!txd && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(n >= 6805 && n <= 6813, "R1", "default start bit clocks", n, 6809);
        rst_n = 1'b0;
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(2);
        check(txd == 1'b1, "R1", "txd after mid-frame reset", int'(txd), 1);

        // R2, R4: back-to-back frames at 128 clocks per bit
        set_rate(16'd4096);
        bit_clks  = 128;
        tx_mon_en = 1'b1;
        send_tx(8'hA5, 1'b1);
        send_tx(8'h01, 1'b1);
        send_tx(8'h80, 1'b1);
        wait_clks(128 * 12);
        check(tx_q.size() == 0, "R4", "queued tx frames left", tx_q.size(), 0);

        // R3: frame length at 64 clocks per bit
        set_rate(16'd8192);
        bit_clks = 64;
        send_tx(8'h5A, 1'b1);
        n = 1;
        while (!tx_ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(n >= 637 && n <= 643, "R3", "frame clocks at word 8192", n, 640);
        wait_clks(200);

        // R5: received bytes
        set_rate(16'd4096);
        bit_clks = 128;
        send_rx(8'h3C, 1'b1);
        send_rx(8'hFE, 1'b1);
        wait_clks(200);

        // R6: framing error, then a held-low line yields nothing more
        c0 = rx_valid_cnt;
        send_rx(8'h55, 1'b0);
        wait_clks(128 * 4);
        check(rx_valid_cnt == c0 + 1, "R6", "reports while line held low", rx_valid_cnt - c0, 1);
        drv_rx = 1'b1;
        wait_clks(128);
        send_rx(8'h96, 1'b1);
        wait_clks(200);

        // R7: short low glitch is ignored
        c0 = rx_valid_cnt;
        drv_rx = 1'b0;
        wait_clks(32);
        drv_rx = 1'b1;
        wait_clks(128 * 12);
        check(rx_valid_cnt == c0, "R7", "reports after glitch", rx_valid_cnt - c0, 0);

        // R9: transmit and receive at the same time
        fork
            send_tx(8'hC3, 1'b1);
            send_rx(8'h24, 1'b1);
        join
        wait_clks(128 * 3);
        check(tx_q.size() == 0 && rx_q.size() == 0, "R9", "full-duplex leftovers",
              tx_q.size() + rx_q.size(), 0);

        // R8: rate change in mid-frame, transmitter looped to receiver
        tx_mon_en = 1'b0;
        loop_en   = 1'b1;
        rx_q.push_back({1'b0, 8'h6B});
        send_tx(8'h6B, 1'b0);
        wait_clks(300);
        set_rate(16'd8192);
        wait_clks(64 * 12);
        check(rx_q.size() == 0, "R8", "loopback byte after rate change", rx_q.size(), 0);
        check(tx_ready == 1'b1, "R8", "tx_ready after frame", int'(tx_ready), 1);

        // R10: highest word, loopback and line check
        set_rate(16'hFFFF);
        bit_clks  = 8;
        tx_mon_en = 1'b1;
        rx_q.push_back({1'b0, 8'hD2});
        rx_q.push_back({1'b0, 8'h2D});
        send_tx(8'hD2, 1'b1);
        send_tx(8'h2D, 1'b1);
        wait_clks(200);
        check(rx_q.size() == 0, "R10", "max-rate rx leftovers", rx_q.size(), 0);
        check(tx_q.size() == 0, "R10", "max-rate tx leftovers", tx_q.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule